// File: doc/BRIEF.md
# Accumulator Test-and-Modify Skip Unit

This unit executes the register-operate instructions of a 12-bit processor that either examine or rewrite the two main accumulators (called J and K here), the overflow bit and the flag bit. A test instruction checks one condition and raises a skip request, which tells the sequencer to pass over the next instruction. A modify instruction clears, complements, sets to all ones, increments or negates a word, or clears, complements or sets a status bit.

Each cycle the unit takes an instruction word, a valid strobe and the current J, K, overflow and flag values. One clock later it presents the updated register values and the skip request. Program-counter sequencing, interrupts and power-fail handling belong to the surrounding processor.

In every instruction the top six bits choose the target. Octal 15 selects J, 16 selects K, 17 selects the pair and 14 selects the status bits. The low octal digit chooses the condition to test. When a test names the pair, both registers must meet the condition. The one exception is the non-zero test, which is satisfied when either register is non-zero.

Top module: `amt_top`

## Requirements
- R1: While rst_n is low, j_o, k_o, ovf_o, flag_o and skip_o are all zero, whatever the inputs are.
- R2: Results appear on the outputs one clock after the inputs are sampled. While valid_i is low, the outputs copy j_i, k_i, ovf_i and flag_i unchanged and skip_o is 0.
- R3: The octal codes 1505, 1605 and 1705 request a skip when J is zero, when K is zero and when both are zero. The codes 1501, 1601 and 1701 request a skip when J is non-zero, when K is non-zero and when at least one of them is non-zero.
- R4: The octal codes 1502, 1602 and 1702 request a skip when the sign bit (bit WIDTH-1) is 0 in J, in K, or in both. Zero counts as positive. The codes 1506, 1606 and 1706 request a skip when the sign bit is 1 in J, in K, or in both.
- R5: The octal codes 15x0, 16x0 and 17x0 act on J, on K and on both. The middle digit x selects the action: 1 clears the word, 2 complements it, 3 sets it to all ones.
- R6: The octal codes 1504, 1604 and 1704 increment J, K or both. The codes 1524, 1624 and 1724 replace the word with its two's-complement negative. Both wrap modulo 2^WIDTH and leave the overflow bit unchanged.
- R7: Overflow operations, in octal: 1445 skips when overflow is 0, 1441 skips when it is 1, 1450 clears it, 1460 inverts it, 1470 sets it.
- R8: Flag operations, in octal: 1405 skips when the flag is 0, 1401 skips when it is 1, 1410 clears it, 1420 inverts it, 1430 sets it.
- R9: Octal 1442 always requests a skip and changes nothing. Octal 1400 changes nothing and does not skip.
- R10: Any other code (for example 1500, 1440, 1503 or 2000) changes no output value and does not skip. A test never changes a value, and a register that the code does not name passes through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_i | input | 12 | Instruction word |
| valid_i | input | 1 | Instruction strobe |
| j_i | input | WIDTH | Current J accumulator |
| k_i | input | WIDTH | Current K accumulator |
| ovf_i | input | 1 | Current overflow bit |
| flag_i | input | 1 | Current flag bit |
| j_o | output | WIDTH | Updated J |
| k_o | output | WIDTH | Updated K |
| ovf_o | output | 1 | Updated overflow bit |
| flag_o | output | 1 | Updated flag bit |
| skip_o | output | 1 | Skip request for the next instruction |

## Verification
The bench targets the pair tests where only one register meets the condition. A design that joins the two registers with the wrong operator skips on 1705 with only J zero, or fails to skip on 1701 with only K non-zero. It also probes the sign tests with zero, 2048 and 4095, and the wrap of increment at 4095 and of negate at zero and 2048. A design that treats zero as non-positive, or lets these operations touch overflow, shows up there. Undecoded neighbours such as 1500, 1440 and 1503 are sent with live data and both status bits set, so a decoder that is too loose changes a value or raises a skip.

// File: rtl/amt_pkg.sv
package amt_pkg;

    localparam int INSTR_W = 12;

    typedef enum logic [2:0] {
        TST_NONE,
        TST_ZERO,
        TST_NONZERO,
        TST_POS,
        TST_NEG,
        TST_ALWAYS
    } test_e;

    typedef enum logic [2:0] {
        MOD_NONE,
        MOD_CLR,
        MOD_CMP,
        MOD_SET,
        MOD_INC,
        MOD_NEG
    } mod_e;

    typedef struct packed {
        logic  on_j;
        logic  on_k;
        logic  on_ovf;
        logic  on_flag;
        test_e test;
        mod_e  mod;
    } ctl_t;

endpackage

// File: rtl/amt_decode.sv
module amt_decode
    import amt_pkg::*;
(
    input  logic [INSTR_W-1:0] instr_i,
    input  logic               valid_i,
    output ctl_t               ctl_o
);

    logic [5:0] grp;
    logic [5:0] op;
    test_e      wtest;
    mod_e       wmod;

    assign grp = instr_i[11:6];
    assign op  = instr_i[5:0];

    // word operations are shared by the J, K and pair groups
    always_comb begin
        wtest = TST_NONE;
        wmod  = MOD_NONE;
        unique case (op)
            6'o05:   wtest = TST_ZERO;
            6'o01:   wtest = TST_NONZERO;
            6'o02:   wtest = TST_POS;
            6'o06:   wtest = TST_NEG;
            6'o10:   wmod  = MOD_CLR;
            6'o20:   wmod  = MOD_CMP;
            6'o30:   wmod  = MOD_SET;
            6'o04:   wmod  = MOD_INC;
            6'o24:   wmod  = MOD_NEG;
            default: ;
        endcase
    end

    always_comb begin
        ctl_o.on_j    = 1'b0;
        ctl_o.on_k    = 1'b0;
        ctl_o.on_ovf  = 1'b0;
        ctl_o.on_flag = 1'b0;
        ctl_o.test    = TST_NONE;
        ctl_o.mod     = MOD_NONE;
        if (valid_i) begin
            unique case (grp)
                6'o15, 6'o16, 6'o17: begin
                    if (wtest != TST_NONE || wmod != MOD_NONE) begin
                        ctl_o.on_j = (grp != 6'o16);
                        ctl_o.on_k = (grp != 6'o15);
                        ctl_o.test = wtest;
                        ctl_o.mod  = wmod;
                    end
                end
                6'o14: begin
                    unique case (op)
                        6'o45: begin ctl_o.on_ovf  = 1'b1; ctl_o.test = TST_ZERO;    end
                        6'o41: begin ctl_o.on_ovf  = 1'b1; ctl_o.test = TST_NONZERO; end
                        6'o50: begin ctl_o.on_ovf  = 1'b1; ctl_o.mod  = MOD_CLR;     end
                        6'o60: begin ctl_o.on_ovf  = 1'b1; ctl_o.mod  = MOD_CMP;     end
                        6'o70: begin ctl_o.on_ovf  = 1'b1; ctl_o.mod  = MOD_SET;     end
                        6'o05: begin ctl_o.on_flag = 1'b1; ctl_o.test = TST_ZERO;    end
                        6'o01: begin ctl_o.on_flag = 1'b1; ctl_o.test = TST_NONZERO; end
                        6'o10: begin ctl_o.on_flag = 1'b1; ctl_o.mod  = MOD_CLR;     end
                        6'o20: begin ctl_o.on_flag = 1'b1; ctl_o.mod  = MOD_CMP;     end
                        6'o30: begin ctl_o.on_flag = 1'b1; ctl_o.mod  = MOD_SET;     end
                        6'o42: ctl_o.test = TST_ALWAYS;
                        default: ;
                    endcase
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/amt_word_lane.sv
module amt_word_lane
    import amt_pkg::*;
#(
    parameter int WIDTH = 12
) (
    input  logic [WIDTH-1:0] val_i,
    input  logic             en_i,
    input  mod_e             mod_i,
    output logic [WIDTH-1:0] val_o,
    output logic             is_zero_o,
    output logic             is_neg_o
);

    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    assign is_zero_o = (val_i == '0);
    assign is_neg_o  = val_i[WIDTH-1];

    always_comb begin
        val_o = val_i;
        if (en_i) begin
            unique case (mod_i)
                MOD_CLR: val_o = '0;
                MOD_CMP: val_o = ~val_i;
                MOD_SET: val_o = '1;
                MOD_INC: val_o = val_i + ONE;
                MOD_NEG: val_o = ~val_i + ONE;
                default: val_o = val_i;
            endcase
        end
    end

endmodule

// File: rtl/amt_bit_op.sv
module amt_bit_op
    import amt_pkg::*;
(
    input  logic bit_i,
    input  logic en_i,
    input  mod_e mod_i,
    output logic bit_o
);

    always_comb begin
        bit_o = bit_i;
        if (en_i) begin
            unique case (mod_i)
                MOD_CLR: bit_o = 1'b0;
                MOD_CMP: bit_o = ~bit_i;
                MOD_SET: bit_o = 1'b1;
                default: bit_o = bit_i;
            endcase
        end
    end

endmodule

// File: rtl/amt_skip_eval.sv
module amt_skip_eval
    import amt_pkg::*;
(
    input  test_e      test_i,
    input  logic       on_j_i,
    input  logic       on_k_i,
    input  logic       on_ovf_i,
    input  logic [1:0] zero_i,
    input  logic [1:0] neg_i,
    input  logic       ovf_i,
    input  logic       flag_i,
    output logic       skip_o
);

    logic pair;
    logic word;
    logic bsel;

    assign pair = on_j_i & on_k_i;
    assign word = on_j_i | on_k_i;
    assign bsel = on_ovf_i ? ovf_i : flag_i;

    always_comb begin
        skip_o = 1'b0;
        if (test_i == TST_ALWAYS) begin
            skip_o = 1'b1;
        end else if (word) begin
            unique case (test_i)
                TST_ZERO:    skip_o = pair ? (zero_i[0] & zero_i[1])
                                           : (on_j_i ? zero_i[0] : zero_i[1]);
                TST_NONZERO: skip_o = pair ? (~zero_i[0] | ~zero_i[1])
                                           : (on_j_i ? ~zero_i[0] : ~zero_i[1]);
                TST_POS:     skip_o = pair ? (~neg_i[0] & ~neg_i[1])
                                           : (on_j_i ? ~neg_i[0] : ~neg_i[1]);
                TST_NEG:     skip_o = pair ? (neg_i[0] & neg_i[1])
                                           : (on_j_i ? neg_i[0] : neg_i[1]);
                default:     skip_o = 1'b0;
            endcase
        end else begin
            unique case (test_i)
                TST_ZERO:    skip_o = ~bsel;
                TST_NONZERO: skip_o = bsel;
                default:     skip_o = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/amt_top.sv
module amt_top
    import amt_pkg::*;
#(
    parameter int WIDTH = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INSTR_W-1:0] instr_i,
    input  logic               valid_i,
    input  logic [WIDTH-1:0]   j_i,
    input  logic [WIDTH-1:0]   k_i,
    input  logic               ovf_i,
    input  logic               flag_i,
    output logic [WIDTH-1:0]   j_o,
    output logic [WIDTH-1:0]   k_o,
    output logic               ovf_o,
    output logic               flag_o,
    output logic               skip_o
);

    localparam int LANES = 2;

    typedef struct packed {
        logic [WIDTH-1:0] j;
        logic [WIDTH-1:0] k;
        logic             ovf;
        logic             flag;
        logic             skip;
    } state_t;

    ctl_t             ctl;
    logic [WIDTH-1:0] lane_in  [LANES];
    logic [WIDTH-1:0] lane_out [LANES];
    logic [LANES-1:0] lane_en;
    logic [LANES-1:0] lane_zero;
    logic [LANES-1:0] lane_neg;
    logic             ovf_new;
    logic             flag_new;
    logic             skip_new;
    state_t           state_d;
    state_t           state_q;

    amt_decode u_dec (
        .instr_i (instr_i),
        .valid_i (valid_i),
        .ctl_o   (ctl)
    );

    assign lane_in[0] = j_i;
    assign lane_in[1] = k_i;
    assign lane_en[0] = ctl.on_j;
    assign lane_en[1] = ctl.on_k;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        amt_word_lane #(.WIDTH(WIDTH)) u_lane (
            .val_i     (lane_in[l]),
            .en_i      (lane_en[l]),
            .mod_i     (ctl.mod),
            .val_o     (lane_out[l]),
            .is_zero_o (lane_zero[l]),
            .is_neg_o  (lane_neg[l])
        );
    end

    amt_bit_op u_ovf (
        .bit_i (ovf_i),
        .en_i  (ctl.on_ovf),
        .mod_i (ctl.mod),
        .bit_o (ovf_new)
    );

    amt_bit_op u_flag (
        .bit_i (flag_i),
        .en_i  (ctl.on_flag),
        .mod_i (ctl.mod),
        .bit_o (flag_new)
    );

    amt_skip_eval u_skip (
        .test_i   (ctl.test),
        .on_j_i   (ctl.on_j),
        .on_k_i   (ctl.on_k),
        .on_ovf_i (ctl.on_ovf),
        .zero_i   (lane_zero),
        .neg_i    (lane_neg),
        .ovf_i    (ovf_i),
        .flag_i   (flag_i),
        .skip_o   (skip_new)
    );

    always_comb begin
        state_d      = state_q;
        state_d.j    = lane_out[0];
        state_d.k    = lane_out[1];
        state_d.ovf  = ovf_new;
        state_d.flag = flag_new;
        state_d.skip = skip_new;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign j_o    = state_q.j;
    assign k_o    = state_q.k;
    assign ovf_o  = state_q.ovf;
    assign flag_o = state_q.flag;
    assign skip_o = state_q.skip;

endmodule

// File: rtl/amt_checker.sv
module amt_checker #(
    parameter int WIDTH = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic [11:0]      instr_i,
    input logic             valid_i,
    input logic [WIDTH-1:0] j_i,
    input logic [WIDTH-1:0] k_i,
    input logic             ovf_i,
    input logic             flag_i,
    input logic [WIDTH-1:0] j_o,
    input logic [WIDTH-1:0] k_o,
    input logic             ovf_o,
    input logic             flag_o,
    input logic             skip_o
);

    a_r2_idle_pass: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> (j_o == $past(j_i)) && (k_o == $past(k_i)) &&
                     (ovf_o == $past(ovf_i)) && (flag_o == $past(flag_i)) && !skip_o);

    a_r3_pair_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && instr_i == 12'o1705) |=>
            skip_o == (($past(j_i) == '0) && ($past(k_i) == '0)));

    a_r4_neg_j: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && instr_i == 12'o1506) |=> skip_o == $past(j_i[WIDTH-1]));

    a_r5_set_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && instr_i == 12'o1730) |=> (j_o == '1) && (k_o == '1));

    a_r6_keep_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && (instr_i inside {12'o1504, 12'o1604, 12'o1704,
                                     12'o1524, 12'o1624, 12'o1724}))
            |=> ovf_o == $past(ovf_i));

    a_r6_neg_sum: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && instr_i == 12'o1524) |=> (j_o + $past(j_i)) == '0);

    a_r7_cmp_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && instr_i == 12'o1460) |=> ovf_o != $past(ovf_i));

    a_r8_set_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && instr_i == 12'o1430) |=> flag_o);

    a_r9_always_skip: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && instr_i == 12'o1442) |=> skip_o);

    a_r10_skip_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        skip_o |-> (j_o == $past(j_i)) && (k_o == $past(k_i)) &&
                   (ovf_o == $past(ovf_i)) && (flag_o == $past(flag_i)));

endmodule

bind amt_top amt_checker #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/sim_amt_top.sv
module sim_amt_top;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 12;
    localparam int MODV       = 1 << W;

    logic         clk   = 1'b0;
    logic         rst_n = 1'b0;
    logic [11:0]  instr = '0;
    logic         valid = 1'b0;
    logic [W-1:0] j     = '0;
    logic [W-1:0] k     = '0;
    logic         ovf   = 1'b0;
    logic         flag  = 1'b0;
    logic [W-1:0] j_o;
    logic [W-1:0] k_o;
    logic         ovf_o;
    logic         flag_o;
    logic         skip_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    amt_top #(.WIDTH(W)) u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .instr_i (instr),
        .valid_i (valid),
        .j_i     (j),
        .k_i     (k),
        .ovf_i   (ovf),
        .flag_i  (flag),
        .j_o     (j_o),
        .k_o     (k_o),
        .ovf_o   (ovf_o),
        .flag_o  (flag_o),
        .skip_o  (skip_o)
    );

    // behavioural reference, written from the requirements
    function automatic void model(input int ins, input bit v, input int a, input int b,
                                  input bit o, input bit f,
                                  output int ea, output int eb, output bit eo,
                                  output bit ef, output bit es, output string tag);
        int  hi = ins / 64;
        int  lo = ins % 64;
        bit  ua = (hi == 8'o15) || (hi == 8'o17);
        bit  ub = (hi == 8'o16) || (hi == 8'o17);
        bit  both = ua && ub;
        int  half = MODV / 2;
        ea = a; eb = b; eo = o; ef = f; es = 0; tag = "R10";
        if (!v) begin
            tag = "R2";
            return;
        end
        if (ua || ub) begin
            case (lo)
                8'o05: begin tag = "R3";
                    es = both ? (a == 0 && b == 0) : (ua ? a == 0 : b == 0); end
                8'o01: begin tag = "R3";
                    es = both ? (a != 0 || b != 0) : (ua ? a != 0 : b != 0); end
                8'o02: begin tag = "R4";
                    es = both ? (a < half && b < half) : (ua ? a < half : b < half); end
                8'o06: begin tag = "R4";
                    es = both ? (a >= half && b >= half) : (ua ? a >= half : b >= half); end
                8'o10: begin tag = "R5"; if (ua) ea = 0; if (ub) eb = 0; end
                8'o20: begin tag = "R5"; if (ua) ea = MODV - 1 - a; if (ub) eb = MODV - 1 - b; end
                8'o30: begin tag = "R5"; if (ua) ea = MODV - 1; if (ub) eb = MODV - 1; end
                8'o04: begin tag = "R6"; if (ua) ea = (a + 1) % MODV; if (ub) eb = (b + 1) % MODV; end
                8'o24: begin tag = "R6"; if (ua) ea = (MODV - a) % MODV; if (ub) eb = (MODV - b) % MODV; end
                default: tag = "R10";
            endcase
        end else if (hi == 8'o14) begin
            case (lo)
                8'o45: begin tag = "R7"; es = !o; end
                8'o41: begin tag = "R7"; es = o; end
                8'o50: begin tag = "R7"; eo = 0; end
                8'o60: begin tag = "R7"; eo = !o; end
                8'o70: begin tag = "R7"; eo = 1; end
                8'o05: begin tag = "R8"; es = !f; end
                8'o01: begin tag = "R8"; es = f; end
                8'o10: begin tag = "R8"; ef = 0; end
                8'o20: begin tag = "R8"; ef = !f; end
                8'o30: begin tag = "R8"; ef = 1; end
                8'o42: begin tag = "R9"; es = 1; end
                8'o00: tag = "R9";
                default: tag = "R10";
            endcase
        end
    endfunction

    // called at a falling edge: drive, wait one clock, compare
    task automatic step(input int ins, input bit v, input int a, input int b,
                        input bit o, input bit f);
        int ea, eb;
        bit eo, ef, es;
        string tag;
        instr = ins[11:0]; valid = v; j = a[W-1:0]; k = b[W-1:0]; ovf = o; flag = f;
        model(ins, v, a % MODV, b % MODV, o, f, ea, eb, eo, ef, es, tag);
        @(negedge clk);
        checks++;
        if (j_o !== ea[W-1:0] || k_o !== eb[W-1:0] || ovf_o !== eo ||
            flag_o !== ef || skip_o !== es) begin
            fails++;
            $display("FAIL %s code %o: got j=%0d k=%0d ovf=%0b flag=%0b skip=%0b, expected j=%0d k=%0d ovf=%0b flag=%0b skip=%0b",
                     tag, ins, j_o, k_o, ovf_o, flag_o, skip_o, ea, eb, eo, ef, es);
        end
    endtask

    int codes [0:39] = '{
        12'o1505, 12'o1605, 12'o1705, 12'o1501, 12'o1601, 12'o1701,
        12'o1502, 12'o1602, 12'o1702, 12'o1506, 12'o1606, 12'o1706,
        12'o1510, 12'o1610, 12'o1710, 12'o1520, 12'o1620, 12'o1720,
        12'o1530, 12'o1630, 12'o1730, 12'o1504, 12'o1604, 12'o1704,
        12'o1524, 12'o1624, 12'o1724, 12'o1445, 12'o1441, 12'o1450,
        12'o1460, 12'o1470, 12'o1405, 12'o1401, 12'o1410, 12'o1420,
        12'o1430, 12'o1442, 12'o1400, 12'o1503
    };

    function automatic int pick_word();
        case ($urandom % 6)
            0: return 0;
            1: return MODV / 2;
            2: return MODV - 1;
            3: return 1;
            default: return int'($urandom % MODV);
        endcase
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout, expected completion");
        finish_run();
    end

    initial begin
        // R1: live inputs while reset is held
        instr = 12'o1730; valid = 1'b1; j = 12'd5; k = 12'd9; ovf = 1'b1; flag = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        checks++;
        if (j_o !== '0 || k_o !== '0 || ovf_o !== 1'b0 || flag_o !== 1'b0 || skip_o !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset: got j=%0d k=%0d ovf=%0b flag=%0b skip=%0b, expected all zero",
                     j_o, k_o, ovf_o, flag_o, skip_o);
        end
        rst_n = 1'b1;

        // R2: strobe low passes inputs through
        step(12'o1730, 0, 100, 200, 1, 0);
        step(12'o1442, 0, 7, 8, 0, 1);
        // R3 zero and non-zero, single and pair
        step(12'o1505, 1, 0, 5, 0, 0);
        step(12'o1505, 1, 7, 0, 0, 0);
        step(12'o1605, 1, 7, 0, 0, 0);
        step(12'o1705, 1, 0, 1, 0, 0);
        step(12'o1705, 1, 0, 0, 0, 0);
        step(12'o1701, 1, 0, 0, 0, 0);
        step(12'o1701, 1, 0, 3, 0, 0);
        step(12'o1601, 1, 3, 0, 0, 0);
        // R4 sign tests, zero is positive
        step(12'o1502, 1, 0, 4095, 0, 0);
        step(12'o1502, 1, 2048, 0, 0, 0);
        step(12'o1702, 1, 5, 2048, 0, 0);
        step(12'o1702, 1, 2047, 0, 0, 0);
        step(12'o1706, 1, 2048, 4095, 0, 0);
        step(12'o1706, 1, 2048, 1, 0, 0);
        step(12'o1606, 1, 0, 4095, 0, 0);
        // R5 clear, complement, set
        step(12'o1510, 1, 123, 456, 1, 1);
        step(12'o1620, 1, 123, 456, 0, 0);
        step(12'o1730, 1, 0, 17, 0, 0);
        step(12'o1710, 1, 99, 77, 0, 1);
        // R6 increment and negate wrap, overflow untouched
        step(12'o1504, 1, 4095, 9, 1, 0);
        step(12'o1624, 1, 3, 0, 1, 0);
        step(12'o1724, 1, 1, 2048, 0, 1);
        step(12'o1704, 1, 4095, 4095, 0, 0);
        // R7 overflow operations
        step(12'o1445, 1, 1, 1, 0, 1);
        step(12'o1445, 1, 1, 1, 1, 0);
        step(12'o1441, 1, 1, 1, 1, 0);
        step(12'o1450, 1, 1, 1, 1, 1);
        step(12'o1460, 1, 1, 1, 0, 0);
        step(12'o1470, 1, 1, 1, 0, 0);
        // R8 flag operations
        step(12'o1405, 1, 2, 2, 1, 0);
        step(12'o1401, 1, 2, 2, 0, 1);
        step(12'o1410, 1, 2, 2, 1, 1);
        step(12'o1420, 1, 2, 2, 0, 1);
        step(12'o1430, 1, 2, 2, 1, 0);
        // R9 unconditional skip and no-op
        step(12'o1442, 1, 0, 0, 0, 0);
        step(12'o1400, 1, 0, 0, 1, 1);
        // R10 undecoded neighbours leave everything alone
        step(12'o1500, 1, 11, 22, 1, 1);
        step(12'o1440, 1, 11, 22, 1, 1);
        step(12'o1503, 1, 0, 0, 1, 1);
        step(12'o1600, 1, 11, 22, 1, 1);
        step(12'o2000, 1, 0, 22, 1, 1);
        step(12'o1474, 1, 11, 0, 0, 1);

        // mixed traffic against the model, every clock
        for (int i = 0; i < 3000; i++) begin
            int ins;
            ins = ($urandom % 8 == 0) ? int'($urandom % 4096) : codes[$urandom % 40];
            step(ins, ($urandom % 5) != 0, pick_word(), pick_word(),
                 1'($urandom), 1'($urandom));
        end

        finish_run();
    end

endmodule